// File: doc/BRIEF.md
# Segment access permission checker

This block checks one memory access per cycle against the cached attributes of the segment register that the access goes through. It reports a protection fault when the access breaks a rule. The inputs per access are:

- the access kind: instruction fetch, data read or data write;
- the starting offset and the length of the access;
- the segment's limit, its type bits and a marker that says the register holds a null selector;
- which segment register is used;
- a flag saying the access is a vector operand that must be 16-byte aligned.

The block has a single registered stage. One clock after a request, it raises a fault strobe for exactly one cycle and gives a 3-bit cause code. The code is 0 when the access is legal.

When several rules are broken at once, only the highest-priority cause is reported. The order, from highest to lowest, is:

1. null selector;
2. type or permission;
3. limit;
4. alignment.

The limit test is done on the last byte of the access. It uses one extra carry bit, so an access that runs past the top of the offset space is also caught as a limit fault.

Top module: `seg_access_chk`

## Requirements
- R1: An access whose last byte (offset + length_minus_one) is greater than `seg_limit` faults with cause 5. An access whose last byte equals the limit does not fault.
- R2: An instruction fetch (kind 0) through a data segment (`seg_code`=0) faults with cause 2.
- R3: A data write (kind 2) faults with cause 3 in either of two cases: the segment is a code segment, or it is a data segment with `seg_rw`=0 (read-only).
- R4: A data read (kind 1, and also kind 3) from a code segment with `seg_rw`=0 (execute-only) faults with cause 4. Reads from code segments with `seg_rw`=1 do not fault on type, and neither do reads from any data segment.
- R5: An access through ES, DS, FS or GS (`seg_sel` 0, 3, 4, 5) with `seg_null`=1 faults with cause 1. For CS, SS and the unused codes (`seg_sel` 1, 2, 6, 7), `seg_null` is ignored.
- R6: An access with `req_align16`=1 whose offset is not a multiple of 16 faults with cause 6.
- R7: When several causes apply, the reported cause is the first applicable one in this order: null (1), type (2/3/4), limit (5), alignment (6).
- R8: The last-byte sum is formed without wraparound. An access that crosses the top of the offset space therefore faults with cause 5, even when the limit is all ones.
- R9: Timing and reset:
  - `flt_valid` is registered. It rises one cycle after a faulting request and lasts one cycle.
  - `flt_cause` carries the cause in that same cycle. It is 0 one cycle after any cycle without a request.
  - Without a request, no fault is reported, whatever the other inputs are.
  - During and right after reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_offset | input | OFS_W | Effective offset of the first byte |
| req_len_m1 | input | LEN_W | Access length in bytes minus one |
| req_align16 | input | 1 | Vector operand that must be 16-byte aligned |
| seg_sel | input | 3 | Segment register: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| seg_limit | input | OFS_W | Highest valid offset in the segment |
| seg_code | input | 1 | 1 for a code segment, 0 for a data segment |
| seg_rw | input | 1 | Code segment: readable. Data segment: writable |
| seg_null | input | 1 | Register holds a null selector |
| flt_valid | output | 1 | One-cycle fault strobe |
| flt_cause | output | 3 | Cause code, 0 when there is no fault |

## Verification
The bench probes the limit edge on both sides of it: the last byte equal to the limit, and the last byte one past it. A checker that compares the start offset, or uses the wrong comparison, passes the first case or misses the second. Offsets near the top of the offset space, with an all-ones limit, expose a sum that wraps: such a design would let a crossing access through as legal. Combined faults check the priority order, and a null marker on CS or SS checks that only ES, DS, FS and GS are tested for null. A request-free cycle with bad attributes, and the cycle after a fault, show whether the strobe leaks without a request or stretches past one cycle.

// File: rtl/seg_access_chk.sv
module seg_access_chk #(
  parameter int OFS_W = 32,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len_m1,
  input  logic             req_align16,
  input  logic [2:0]       seg_sel,
  input  logic [OFS_W-1:0] seg_limit,
  input  logic             seg_code,
  input  logic             seg_rw,
  input  logic             seg_null,
  output logic             flt_valid,
  output logic [2:0]       flt_cause
);

  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_WRITE = 2'd2;
  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_NULL  = 3'd1;
  localparam logic [2:0] C_EXEC  = 3'd2;
  localparam logic [2:0] C_WRITE = 3'd3;
  localparam logic [2:0] C_READ  = 3'd4;
  localparam logic [2:0] C_LIMIT = 3'd5;
  localparam logic [2:0] C_ALIGN = 3'd6;
  localparam int SUM_W = OFS_W + 1;

  wire data_sreg = (seg_sel == 3'd0) || (seg_sel == 3'd3) ||
                   (seg_sel == 3'd4) || (seg_sel == 3'd5);
  wire is_fetch  = (req_kind == K_FETCH);
  wire is_write  = (req_kind == K_WRITE);
  wire is_read   = !is_fetch && !is_write;

  logic [SUM_W-1:0] last_byte;
  assign last_byte = {1'b0, req_offset} + {{(SUM_W-LEN_W){1'b0}}, req_len_m1};

  wire null_bad  = data_sreg && seg_null;
  wire fetch_bad = is_fetch && !seg_code;
  wire write_bad = is_write && (seg_code || !seg_rw);
  wire read_bad  = is_read && seg_code && !seg_rw;
  wire limit_bad = last_byte > {1'b0, seg_limit};
  wire align_bad = req_align16 && (req_offset[3:0] != 4'd0);

  logic [2:0] cause_d;
  always_comb begin
    if (null_bad)       cause_d = C_NULL;
    else if (fetch_bad) cause_d = C_EXEC;
    else if (write_bad) cause_d = C_WRITE;
    else if (read_bad)  cause_d = C_READ;
    else if (limit_bad) cause_d = C_LIMIT;
    else if (align_bad) cause_d = C_ALIGN;
    else                cause_d = C_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_cause <= C_NONE;
    end else begin
      flt_valid <= req_valid && (cause_d != C_NONE);
      flt_cause <= req_valid ? cause_d : C_NONE;
    end
  end

  // R9
  strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> $past(req_valid))
    else $error("strobe without request");

  // R9
  cause_pairs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_cause != 3'd0) |-> flt_valid)
    else $error("cause without strobe");

  // R5
  null_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_null && seg_sel == 3'd3) |=> (flt_valid && flt_cause == 3'd1))
    else $error("null DS not reported");

  // R1
  beyond_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_offset > seg_limit) |=> flt_valid)
    else $error("offset past limit passed");

  // R2
  fetch_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0 && !seg_code) |=> flt_valid)
    else $error("fetch from data segment passed");

  // R6
  misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_align16 && req_offset[3:0] != 4'd0) |=> flt_valid)
    else $error("misaligned vector passed");

endmodule

// File: tb/seg_access_chk_test.sv
module seg_access_chk_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_offset = '0;
  logic [3:0]  req_len_m1 = '0;
  logic        req_align16 = 1'b0;
  logic [2:0]  seg_sel = '0;
  logic [31:0] seg_limit = '0;
  logic        seg_code = 1'b0;
  logic        seg_rw = 1'b0;
  logic        seg_null = 1'b0;
  logic        flt_valid;
  logic [2:0]  flt_cause;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_access_chk uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_offset(req_offset), .req_len_m1(req_len_m1), .req_align16(req_align16),
    .seg_sel(seg_sel), .seg_limit(seg_limit), .seg_code(seg_code),
    .seg_rw(seg_rw), .seg_null(seg_null), .flt_valid(flt_valid), .flt_cause(flt_cause)
  );

  typedef struct packed {
    logic [1:0]  k;
    logic [2:0]  s;
    logic        c;
    logic        rw;
    logic        nl;
    logic        al;
    logic [31:0] off;
    logic [3:0]  len;
    logic [31:0] lim;
    logic [2:0]  ex;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam logic [31:0] L16 = 32'h0000_FFFF;
  localparam logic [31:0] LMAX = 32'hFFFF_FFFF;
  localparam vec_t VEC [NV] = '{
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h10,        4'd3,  L16,  3'd0, 8'd4}, // R4 data read ok
    {2'd0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h100,       4'd0,  L16,  3'd0, 8'd2}, // R2 fetch code ok
    {2'd0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h100,       4'd0,  L16,  3'd2, 8'd2}, // R2
    {2'd2, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h40,        4'd1,  L16,  3'd3, 8'd3}, // R3 read-only
    {2'd2, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h40,        4'd1,  L16,  3'd0, 8'd3}, // R3 writable ok
    {2'd2, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h40,        4'd1,  L16,  3'd3, 8'd3}, // R3 code write
    {2'd1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h80,        4'd3,  L16,  3'd4, 8'd4}, // R4 exec-only
    {2'd3, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h80,        4'd3,  L16,  3'd4, 8'd4}, // R4 kind 3
    {2'd1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h80,        4'd3,  L16,  3'd0, 8'd4}, // R4 readable code
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 32'h20,        4'd0,  L16,  3'd1, 8'd5}, // R5 DS
    {2'd1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h20,        4'd0,  L16,  3'd1, 8'd5}, // R5 ES
    {2'd1, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'h20,        4'd0,  L16,  3'd0, 8'd5}, // R5 SS ignored
    {2'd0, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h20,        4'd0,  L16,  3'd0, 8'd5}, // R5 CS ignored
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFD,      4'd3,  L16,  3'd5, 8'd1}, // R1 over by one
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFC,      4'd3,  L16,  3'd0, 8'd1}, // R1 exact
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h18,        4'd15, L16,  3'd6, 8'd6}, // R6
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h20,        4'd15, L16,  3'd0, 8'd6}, // R6 aligned
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFE, 4'd3,  LMAX, 3'd5, 8'd8}, // R8 wrap
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFC, 4'd3,  LMAX, 3'd0, 8'd8}, // R8 top ok
    {2'd2, 3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1_0001,    4'd0,  L16,  3'd1, 8'd7}, // R7 null wins
    {2'd2, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1_0001,    4'd0,  L16,  3'd3, 8'd7}, // R7 type wins
    {2'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h1_0001,    4'd0,  L16,  3'd5, 8'd7}  // R7 limit wins
  };

  task automatic check(input string tag, input logic v, input logic [2:0] c,
                       input logic ev, input logic [2:0] ec);
    n_run++;
    if (v !== ev || c !== ec) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b cause=%0d, expected valid=%0b cause=%0d",
               tag, v, c, ev, ec);
    end
  endtask

  task automatic drive(input vec_t t, input logic vld);
    req_kind = t.k; seg_sel = t.s; seg_code = t.c; seg_rw = t.rw;
    seg_null = t.nl; req_align16 = t.al; req_offset = t.off;
    req_len_m1 = t.len; seg_limit = t.lim; req_valid = vld;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", flt_valid, flt_cause, 1'b0, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", flt_valid, flt_cause, 1'b0, 3'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R%0d vector %0d", VEC[i].req, i), flt_valid, flt_cause,
            VEC[i].ex != 3'd0, VEC[i].ex);
    end

    // R9: strobe lasts one cycle
    drive(VEC[2], 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 strobe up", flt_valid, flt_cause, 1'b1, 3'd2);
    @(negedge clk);
    check("R9 strobe one cycle", flt_valid, flt_cause, 1'b0, 3'd0);

    // R9: bad attributes without a request raise nothing
    drive(VEC[19], 1'b0);
    @(negedge clk);
    check("R9 no request", flt_valid, flt_cause, 1'b0, 3'd0);

    // R9: back-to-back requests
    drive(VEC[6], 1'b1);
    @(negedge clk);
    check("R9 back-to-back first", flt_valid, flt_cause, 1'b1, 3'd4);
    drive(VEC[0], 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 back-to-back second", flt_valid, flt_cause, 1'b0, 3'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule